// File: doc/BRIEF.md
# Hexadecimal Text Report Transmitter for Infrared Frames

This block takes one decoded infrared frame record and sends it over an asynchronous serial line as readable text. The record holds the number of captured bits, the decision threshold, one high duration and one low duration per captured bit, and a 32-bit result word. A single-cycle `start` strobe copies the whole record into internal storage. After that the source may change freely while the report goes out.

The report has three lines, each closed by carriage return (0x0D) and line feed (0x0A). Every byte value is sent as two uppercase hexadecimal ASCII characters. A built-in transmitter sends each character at a baud rate set by parameters and derived from the system clock frequency. `busy` stays high for the whole report. `done` pulses once when the last character has left the line.

Top module: `ir_hex_report`

## Requirements
- R1: Each hex byte is sent as two characters, upper nibble first. A nibble below 10 maps to 0x30 plus its value, and a nibble from 10 to 15 maps to 0x37 plus its value (uppercase 'A' to 'F').
- R2: Line one is the hex of (bit count × 2) as one byte, then 0x20, then the hex of the threshold byte, then 0x0D and 0x0A.
- R3: Line two holds one group per captured bit, index 0 first. Each group is the hex of the high duration, the hex of the low duration, then 0x20. The line ends with 0x0D 0x0A. Bit i's durations sit in bits [8i+7:8i] of `high_dur` and `low_dur`.
- R4: Line three is the four result bytes in hex, bits [31:24] first and [7:0] last, then 0x0D 0x0A.
- R5: Every character is framed as one low start bit, eight data bits least significant first, and one high stop bit, with no parity. Each bit lasts CLK_HZ/BAUD clock cycles.
- R6: `txd` is high whenever no report is in progress.
- R7: `busy` rises in the cycle after a `start` accepted while idle. It stays high through every character of the report and falls in the same cycle that `done` rises.
- R8: `done` is a one-cycle pulse, issued once per report, after the stop bit of the final 0x0A has ended.
- R9: A `start` strobe during a report is ignored. Input changes after the accepting `start` do not alter the report, and no second report follows.
- R10: A bit count above MAX_BITS is treated as MAX_BITS, in both line one and line two.
- R11: With a bit count of zero, line two is only 0x0D 0x0A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe; latches the record and begins a report when idle |
| bit_count | input | $clog2(MAX_BITS+1) | Number of captured bits |
| threshold | input | 8 | Decision threshold byte |
| high_dur | input | MAX_BITS*8 | Packed high durations, bit i in [8i+7:8i] |
| low_dur | input | MAX_BITS*8 | Packed low durations, bit i in [8i+7:8i] |
| result | input | 32 | Decoded result word |
| txd | output | 1 | Serial output line, idle high |
| busy | output | 1 | High for the duration of a report |
| done | output | 1 | One-cycle pulse after the last stop bit |

## Verification
The bench builds the block with CLK_HZ = 80000 and BAUD = 10000, so each serial bit lasts only eight clocks. With that setting, four complete reports of up to 79 characters each finish in a few tens of thousands of cycles. MAX_BITS stays at 12, so a full-length duration line and a bit count of 15 (the clamp case) can both be reached. The other cases are an empty line two, hex letters A to F, and a second `start` plus input changes in the middle of a report. The serial decoder samples at mid-bit with the same eight-clock period, so a wrong bit time, bit order or stop level shows up as a wrong character.

// File: rtl/ir_hex_pkg.sv
package ir_hex_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CNT,
        S_SP1,
        S_THR,
        S_CR1,
        S_LF1,
        S_HI,
        S_LO,
        S_SP2,
        S_CR2,
        S_LF2,
        S_RES,
        S_CR3,
        S_LF3,
        S_DRAIN
    } rpt_state_e;

    localparam logic [7:0] ASC_SP = 8'h20;
    localparam logic [7:0] ASC_CR = 8'h0D;
    localparam logic [7:0] ASC_LF = 8'h0A;

    // digits 0..9 start at 0x30, letters A..F start at 0x41 (0x37 + 10)
    function automatic logic [7:0] nib_to_ascii(input logic [3:0] nib);
        if (nib < 4'd10) begin
            return 8'h30 + {4'h0, nib};
        end
        return 8'h37 + {4'h0, nib};
    endfunction

endpackage

// File: rtl/hex_char_mux.sv
module hex_char_mux
    import ir_hex_pkg::*;
(
    input  logic [7:0] val,
    input  logic       as_hex,
    input  logic       low_nib,
    output logic [7:0] chr
);

    logic [3:0] nib;

    always_comb begin
        nib = low_nib ? val[3:0] : val[7:4];
        chr = as_hex ? nib_to_ascii(nib) : val;
    end

endmodule

// File: rtl/uart_tx8n1.sv
module uart_tx8n1 #(
    parameter  int BIT_CYC = 13020,
    localparam int BW      = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] data,
    output logic       ready,
    output logic       fin,
    output logic       txd
);

    typedef struct packed {
        logic          act;
        logic [9:0]    sh;
        logic [3:0]    bn;
        logic [BW-1:0] bc;
        logic          fin;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        if (!q.act) begin
            if (load) begin
                d.act = 1'b1;
                d.sh  = {1'b1, data, 1'b0};
                d.bn  = 4'd0;
                d.bc  = '0;
            end
        end else if (q.bc == BW'(BIT_CYC - 1)) begin
            d.bc = '0;
            d.sh = {1'b1, q.sh[9:1]};
            if (q.bn == 4'd9) begin
                d.act = 1'b0;
                d.fin = 1'b1;
            end else begin
                d.bn = q.bn + 4'd1;
            end
        end else begin
            d.bc = q.bc + BW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ready = !q.act;
    assign fin   = q.fin;
    assign txd   = q.act ? q.sh[0] : 1'b1;

    a_r5_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.act) |-> !txd);

    a_r5_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act && q.bn == 4'd9) |-> txd);

    a_r5_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act && q.bc != '0) |-> $stable(txd));

endmodule

// File: rtl/report_sequencer.sv
module report_sequencer
    import ir_hex_pkg::*;
#(
    parameter  int MAX_BITS = 12,
    localparam int CNT_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [CNT_W-1:0]      bit_count,
    input  logic [7:0]            threshold,
    input  logic [MAX_BITS*8-1:0] high_dur,
    input  logic [MAX_BITS*8-1:0] low_dur,
    input  logic [31:0]           result,
    input  logic                  chr_ready,
    input  logic                  chr_fin,
    output logic                  chr_valid,
    output logic [7:0]            chr_val,
    output logic                  chr_hex,
    output logic                  chr_low,
    output logic                  busy,
    output logic                  done
);

    typedef struct packed {
        rpt_state_e            st;
        logic                  low;
        logic [CNT_W-1:0]      idx;
        logic [1:0]            rb;
        logic                  busy;
        logic                  done;
        logic [CNT_W-1:0]      cnt;
        logic [7:0]            thr;
        logic [MAX_BITS*8-1:0] hi;
        logic [MAX_BITS*8-1:0] lo;
        logic [31:0]           res;
    } seq_t;

    seq_t q, d;
    logic [7:0] val;
    logic       hex;
    logic       valid;
    logic       fire;
    logic       step;

    // field selection for the current report position
    always_comb begin
        val   = 8'h00;
        hex   = 1'b0;
        valid = 1'b1;
        case (q.st)
            S_CNT:   begin val = 8'({q.cnt, 1'b0}); hex = 1'b1; end
            S_SP1:   val = ASC_SP;
            S_THR:   begin val = q.thr; hex = 1'b1; end
            S_CR1:   val = ASC_CR;
            S_LF1:   val = ASC_LF;
            S_HI:    begin val = q.hi[int'(q.idx)*8 +: 8]; hex = 1'b1; end
            S_LO:    begin val = q.lo[int'(q.idx)*8 +: 8]; hex = 1'b1; end
            S_SP2:   val = ASC_SP;
            S_CR2:   val = ASC_CR;
            S_LF2:   val = ASC_LF;
            S_RES:   begin val = q.res[8*(3 - int'(q.rb)) +: 8]; hex = 1'b1; end
            S_CR3:   val = ASC_CR;
            S_LF3:   val = ASC_LF;
            default: valid = 1'b0;
        endcase
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        fire   = valid && chr_ready;
        step   = fire && (!hex || q.low);

        if (fire && hex && !q.low) begin
            d.low = 1'b1;
        end

        if (step) begin
            d.low = 1'b0;
            case (q.st)
                S_CNT: d.st = S_SP1;
                S_SP1: d.st = S_THR;
                S_THR: d.st = S_CR1;
                S_CR1: d.st = S_LF1;
                S_LF1: begin
                    d.idx = '0;
                    d.st  = (q.cnt == '0) ? S_CR2 : S_HI;
                end
                S_HI:  d.st = S_LO;
                S_LO:  d.st = S_SP2;
                S_SP2: begin
                    if (q.idx == q.cnt - CNT_W'(1)) begin
                        d.st = S_CR2;
                    end else begin
                        d.idx = q.idx + CNT_W'(1);
                        d.st  = S_HI;
                    end
                end
                S_CR2: d.st = S_LF2;
                S_LF2: begin
                    d.rb = 2'd0;
                    d.st = S_RES;
                end
                S_RES: begin
                    if (q.rb == 2'd3) begin
                        d.st = S_CR3;
                    end else begin
                        d.rb = q.rb + 2'd1;
                    end
                end
                S_CR3: d.st = S_LF3;
                S_LF3: d.st = S_DRAIN;
                default: d.st = q.st;
            endcase
        end

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st   = S_CNT;
                    d.busy = 1'b1;
                    d.low  = 1'b0;
                    d.cnt  = (bit_count > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : bit_count;
                    d.thr  = threshold;
                    d.hi   = high_dur;
                    d.lo   = low_dur;
                    d.res  = result;
                end
            end
            S_DRAIN: begin
                if (chr_fin) begin
                    d.st   = S_IDLE;
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign chr_valid = valid;
    assign chr_val   = val;
    assign chr_hex   = hex;
    assign chr_low   = q.low;
    assign busy      = q.busy;
    assign done      = q.done;

    a_r9_record_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start) |=> ($stable(q.thr) && $stable(q.res) &&
                               $stable(q.hi) && $stable(q.lo) && $stable(q.cnt)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    a_r7_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> q.done);

    a_r3_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st inside {S_HI, S_LO, S_SP2}) |-> (q.idx < q.cnt));

    a_r10_count_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.cnt <= CNT_W'(MAX_BITS)));

endmodule

// File: rtl/ir_hex_report.sv
module ir_hex_report
    import ir_hex_pkg::*;
#(
    parameter  int CLK_HZ   = 125_000_000,
    parameter  int BAUD     = 9600,
    parameter  int MAX_BITS = 12,
    localparam int CNT_W    = $clog2(MAX_BITS + 1),
    localparam int BIT_CYC  = CLK_HZ / BAUD
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [CNT_W-1:0]      bit_count,
    input  logic [7:0]            threshold,
    input  logic [MAX_BITS*8-1:0] high_dur,
    input  logic [MAX_BITS*8-1:0] low_dur,
    input  logic [31:0]           result,
    output logic                  txd,
    output logic                  busy,
    output logic                  done
);

    logic       chr_valid;
    logic [7:0] chr_val;
    logic       chr_hex;
    logic       chr_low;
    logic [7:0] tx_data;
    logic       tx_ready;
    logic       tx_fin;
    logic       load;

    report_sequencer #(.MAX_BITS(MAX_BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bit_count (bit_count),
        .threshold (threshold),
        .high_dur  (high_dur),
        .low_dur   (low_dur),
        .result    (result),
        .chr_ready (tx_ready),
        .chr_fin   (tx_fin),
        .chr_valid (chr_valid),
        .chr_val   (chr_val),
        .chr_hex   (chr_hex),
        .chr_low   (chr_low),
        .busy      (busy),
        .done      (done)
    );

    hex_char_mux u_mux (
        .val     (chr_val),
        .as_hex  (chr_hex),
        .low_nib (chr_low),
        .chr     (tx_data)
    );

    assign load = chr_valid && tx_ready;

    uart_tx8n1 #(.BIT_CYC(BIT_CYC)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .data  (tx_data),
        .ready (tx_ready),
        .fin   (tx_fin),
        .txd   (txd)
    );

    a_r1_hex_digit: assert property (@(posedge clk) disable iff (!rst_n)
        (load && chr_hex) |-> ((tx_data >= 8'h30 && tx_data <= 8'h39) ||
                               (tx_data >= 8'h41 && tx_data <= 8'h46)));

    a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    a_r7_busy_during_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> busy);

endmodule

// File: tb/ir_hex_report_test.sv
module ir_hex_report_test;

    localparam int MAXB  = 12;
    localparam int CW    = $clog2(MAXB + 1);
    localparam int BITC  = 8;       // 80000 / 10000
    localparam int HALFC = BITC / 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [CW-1:0]        bit_count = '0;
    logic [7:0]           threshold = '0;
    logic [MAXB*8-1:0]    high_dur = '0;
    logic [MAXB*8-1:0]    low_dur = '0;
    logic [31:0]          result = '0;
    logic                 txd;
    logic                 busy;
    logic                 done;

    int vectors = 0;
    int errors  = 0;
    int done_cnt = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    ir_hex_report #(.CLK_HZ(80_000), .BAUD(10_000), .MAX_BITS(MAXB)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bit_count (bit_count),
        .threshold (threshold),
        .high_dur  (high_dur),
        .low_dur   (low_dur),
        .result    (result),
        .txd       (txd),
        .busy      (busy),
        .done      (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] asc(input logic [3:0] n);
        // R1: digits from 0x30, letters from 0x41
        return (n <= 4'd9) ? (8'd48 + 8'(n)) : (8'd65 + 8'(n) - 8'd10);
    endfunction

    task automatic push_raw(input logic [7:0] c, input string t);
        exp_q.push_back(c);
        tag_q.push_back(t);
    endtask

    task automatic push_hex(input logic [7:0] b, input string t);
        push_raw(asc(b[7:4]), t);
        push_raw(asc(b[3:0]), t);
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic report(input int cnt, input logic [7:0] thr,
                          input logic [MAXB*8-1:0] hi, input logic [MAXB*8-1:0] lo,
                          input logic [31:0] res, input bit disturb);
        int eff;
        eff = (cnt > MAXB) ? MAXB : cnt;
        push_hex(8'(eff * 2), (cnt > MAXB) ? "R10" : "R2");
        push_raw(8'h20, "R2");
        push_hex(thr, "R2");
        push_raw(8'h0D, "R2");
        push_raw(8'h0A, "R2");
        for (int i = 0; i < eff; i++) begin
            push_hex(hi[i*8 +: 8], "R3");
            push_hex(lo[i*8 +: 8], "R3");
            push_raw(8'h20, "R3");
        end
        push_raw(8'h0D, (eff == 0) ? "R11" : "R3");
        push_raw(8'h0A, (eff == 0) ? "R11" : "R3");
        for (int k = 3; k >= 0; k--) push_hex(res[k*8 +: 8], "R4");
        push_raw(8'h0D, "R4");
        push_raw(8'h0A, "R4");

        @(negedge clk);
        bit_count = CW'(cnt);
        threshold = thr;
        high_dur  = hi;
        low_dur   = lo;
        result    = res;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R7 busy after start", busy, 1);
        if (disturb) begin
            // R9: new record and a second strobe mid-report must change nothing
            repeat (300) @(negedge clk);
            bit_count = CW'(5);
            threshold = 8'h11;
            high_dur  = '1;
            low_dur   = '0;
            result    = 32'hFFFF_0000;
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy === 1'b1, "R9 busy kept", busy, 1);
        end
        wait_done();
    endtask

    // monitor: decodes serial characters and compares with the scoreboard
    initial begin
        logic [7:0] rx;
        logic [7:0] ev;
        string      t;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (txd === 1'b0) begin
                repeat (HALFC) @(negedge clk);
                check(txd === 1'b0, "R5 start bit", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BITC) @(negedge clk);
                    rx[i] = txd;
                end
                repeat (BITC) @(negedge clk);
                check(txd === 1'b1, "R5 stop bit", txd, 1);
                check(busy === 1'b1, "R7 busy during char", busy, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected char", rx, 0);
                end else begin
                    ev = exp_q.pop_front();
                    t  = tag_q.pop_front();
                    check(rx === ev, t, rx, ev);
                end
            end
        end
    end

    // done monitor
    always @(negedge clk) begin
        if (rst_n && done === 1'b1) begin
            done_cnt++;
            check(exp_q.size() == 0, "R8 done after last char", exp_q.size(), 0);
            check(busy === 1'b0, "R7 busy low with done", busy, 0);
        end
    end

    // watchdog
    initial begin
        repeat (150_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [MAXB*8-1:0] h;
        logic [MAXB*8-1:0] l;
        repeat (3) @(negedge clk);
        check(txd === 1'b1, "R6 reset txd", txd, 1);
        check(busy === 1'b0, "R7 reset busy", busy, 0);
        check(done === 1'b0, "R8 reset done", done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // full line with A..F nibbles (R1, R3)
        for (int i = 0; i < MAXB; i++) begin
            h[i*8 +: 8] = 8'(8'h19 + 8'(i * 7));
            l[i*8 +: 8] = 8'(8'hA0 + 8'(i * 13));
        end
        report(12, 8'h5D, h, l, 32'hDEAD_BEEF, 1'b0);

        // empty duration line (R11)
        report(0, 8'h00, h, l, 32'h0123_4567, 1'b0);

        // count above limit is clamped (R10)
        for (int i = 0; i < MAXB; i++) begin
            h[i*8 +: 8] = 8'(8'hF0 - 8'(i));
            l[i*8 +: 8] = 8'(i * 21);
        end
        report(15, 8'hFF, h, l, 32'h89AB_CDEF, 1'b0);

        // single bit, disturbed mid-report (R9)
        report(1, 8'h3C, h, l, 32'h0F1E_2D4B, 1'b1);

        check(done_cnt == 4, "R8 one done per report", done_cnt, 4);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd !== 1'b1 || busy !== 1'b0) begin
                check(1'b0, "R6 idle line after report", {busy, txd}, 1);
            end
        end
        check(txd === 1'b1, "R6 idle high", txd, 1);
        check(busy === 1'b0, "R9 no second report", busy, 0);
        check(exp_q.size() == 0, "R8 scoreboard empty", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule